// File: doc/BRIEF.md
# Order-Preserving Spare Column Multiplexer

This block steers the lanes of a set of spare rows onto a chosen subset of the columns of a larger array. There are M source lanes and N destination columns, and an N-bit select mask marks which destination columns are in use. The lowest-numbered source lane goes to the lowest-numbered selected column, the next source lane goes to the next selected column, and so on. Because of this ordering, no two connections ever cross. Each source lane can reach only a sliding window of N−M+1 destinations.

The same switch settings also carry data the other way. Each source lane receives the value driven on the destination column it is paired with. A mask that does not select exactly M columns is illegal. For an illegal mask the block raises an error and drives every output quiet. An optional register stage closes the combinational network. It is enabled by default, which gives a one-cycle latency and a synchronous, active-high reset.

Top module: `spare_col_mux`

## Requirements
- R1: When the mask selects exactly M columns, source lane i appears on the destination column whose index is the i-th smallest set bit of the mask, counting lanes and bits from 0.
- R2: The error output is 1 exactly when the number of set bits in the mask differs from M, and 0 otherwise.
- R3: While the error output is 1, every destination valid flag is 0, all destination data is 0 and all reverse source data is 0.
- R4: With a legal mask, each destination whose mask bit is 0 outputs zero data with its valid flag at 0, and each destination whose mask bit is 1 has its valid flag at 1.
- R5: Source lane i only ever appears on destination indices i through i+N−M.
- R6: For source lanes i < h, their destination indices j and k always satisfy j < k.
- R7: With a legal mask, reverse source lane i carries the reverse input of the i-th smallest selected destination.
- R8: With the register stage enabled, outputs follow the inputs one clock edge later. A synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lanes | input | M*W | Source lane data, lane i at bits [i*W +: W] |
| col_sel | input | N | Destination select mask, bit j selects column j |
| dst_cols | output | N*W | Destination column data, column j at bits [j*W +: W] |
| dst_vld | output | N | Per-column valid flag |
| back_cols | input | N*W | Reverse data presented at the destination columns |
| back_lanes | output | M*W | Reverse data returned to the source lanes |
| cfg_err | output | 1 | Mask does not select exactly M columns |

## Verification
Several properties are checked on every cycle once the register stage holds live data:
- the error flag agrees with the popcount of the previous mask;
- an error leaves all outputs quiet;
- the valid flags equal the previous mask when it is legal, with exactly M of them set;
- the first and last valid columns lie inside the windows that the lowest and highest lanes can reach.

Some properties need known data and are left to the bench's sweep over every mask of a small configuration:
- the data mapping itself, that lane i lands on the i-th selected column;
- the per-lane window and non-crossing order;
- the reverse return path.

// File: rtl/scm_pkg.sv
package scm_pkg;
  // Width needed to hold a count from 0 to n inclusive.
  function automatic integer cnt_bits(input integer n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/scm_rank.sv
// Prefix counter: rank of column j = number of selected columns below j.
module scm_rank #(
  parameter int N_COL = 7,
  parameter int RW    = 3
) (
  input  logic [N_COL-1:0]    sel,
  output logic [N_COL*RW-1:0] rank,
  output logic [RW-1:0]       total
);
  logic [RW-1:0] pre [N_COL+1];
  assign pre[0] = '0;
  for (genvar j = 0; j < N_COL; j++) begin : g_pre
    assign pre[j+1]          = pre[j] + RW'(sel[j]);
    assign rank[j*RW +: RW]  = pre[j];
  end
  assign total = pre[N_COL];
endmodule

// File: rtl/scm_fwd_net.sv
// Forward switch network: each column sees only the lanes of its window.
module scm_fwd_net #(
  parameter int N_COL = 7,
  parameter int M_LN  = 4,
  parameter int W     = 8,
  parameter int RW    = 3
) (
  input  logic [M_LN*W-1:0]   src,
  input  logic [N_COL-1:0]    sel,
  input  logic [N_COL*RW-1:0] rank,
  input  logic                ok,
  output logic [N_COL*W-1:0]  dst,
  output logic [N_COL-1:0]    vld
);
  localparam int K = N_COL - M_LN;

  for (genvar j = 0; j < N_COL; j++) begin : g_col
    logic [W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int i = 0; i < M_LN; i++) begin
        if (i <= j && i + K >= j && rank[j*RW +: RW] == RW'(i))
          pick = src[i*W +: W];
      end
    end
    assign vld[j]          = ok & sel[j];
    assign dst[j*W +: W]   = vld[j] ? pick : '0;
  end
endmodule

// File: rtl/scm_rev_net.sv
// Reverse network: lane i gathers from columns i .. i+K with the same ranks.
module scm_rev_net #(
  parameter int N_COL = 7,
  parameter int M_LN  = 4,
  parameter int W     = 8,
  parameter int RW    = 3
) (
  input  logic [N_COL*W-1:0]  back,
  input  logic [N_COL-1:0]    sel,
  input  logic [N_COL*RW-1:0] rank,
  input  logic                ok,
  output logic [M_LN*W-1:0]   lanes
);
  localparam int K = N_COL - M_LN;

  for (genvar i = 0; i < M_LN; i++) begin : g_lane
    logic [W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int d = 0; d <= K; d++) begin
        if (sel[i+d] && rank[(i+d)*RW +: RW] == RW'(i))
          pick = back[(i+d)*W +: W];
      end
    end
    assign lanes[i*W +: W] = ok ? pick : '0;
  end
endmodule

// File: rtl/spare_col_mux.sv
module spare_col_mux #(
  parameter int N_COL   = 7,
  parameter int M_LN    = 4,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [M_LN*W-1:0]   src_lanes,
  input  logic [N_COL-1:0]    col_sel,
  output logic [N_COL*W-1:0]  dst_cols,
  output logic [N_COL-1:0]    dst_vld,
  input  logic [N_COL*W-1:0]  back_cols,
  output logic [M_LN*W-1:0]   back_lanes,
  output logic                cfg_err
);
  import scm_pkg::*;
  localparam int RW = cnt_bits(N_COL);
  localparam int K  = N_COL - M_LN;

  logic [N_COL*RW-1:0] rank;
  logic [RW-1:0]       total;
  logic                ok;
  logic [N_COL*W-1:0]  c_dst;
  logic [N_COL-1:0]    c_vld;
  logic [M_LN*W-1:0]   c_back;

  scm_rank #(.N_COL(N_COL), .RW(RW)) u_rank (
    .sel(col_sel), .rank(rank), .total(total)
  );

  assign ok = (total == RW'(M_LN));

  scm_fwd_net #(.N_COL(N_COL), .M_LN(M_LN), .W(W), .RW(RW)) u_fwd (
    .src(src_lanes), .sel(col_sel), .rank(rank), .ok(ok),
    .dst(c_dst), .vld(c_vld)
  );

  scm_rev_net #(.N_COL(N_COL), .M_LN(M_LN), .W(W), .RW(RW)) u_rev (
    .back(back_cols), .sel(col_sel), .rank(rank), .ok(ok),
    .lanes(c_back)
  );

  if (REG_OUT) begin : g_reg
    logic live_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        dst_cols   <= '0;
        dst_vld    <= '0;
        back_lanes <= '0;
        cfg_err    <= 1'b0;
        live_q     <= 1'b0;
      end else begin
        dst_cols   <= c_dst;
        dst_vld    <= c_vld;
        back_lanes <= c_back;
        cfg_err    <= ~ok;
        live_q     <= 1'b1;
      end
    end

    // R2: flag tracks the popcount of the mask one edge earlier
    p_err_flag_r2: assert property (@(posedge clk) disable iff (rst)
      live_q |-> (cfg_err == ($countones($past(col_sel)) != M_LN)));
    // R2: a legal result carries exactly M valid columns
    p_vld_count_r2: assert property (@(posedge clk) disable iff (rst)
      (live_q && !cfg_err) |-> ($countones(dst_vld) == M_LN));
    // R3: error keeps every output quiet
    p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (live_q && cfg_err) |-> (dst_vld == '0 && dst_cols == '0 && back_lanes == '0));
    // R4: valid flags mirror a legal mask
    p_vld_mask_r4: assert property (@(posedge clk) disable iff (rst)
      (live_q && !cfg_err) |-> (dst_vld == $past(col_sel)));
    // R5: lowest lane lands in its window
    p_low_window_r5: assert property (@(posedge clk) disable iff (rst)
      (live_q && !cfg_err) |-> (dst_vld[K:0] != '0));
    // R5: highest lane lands in its window
    p_high_window_r5: assert property (@(posedge clk) disable iff (rst)
      (live_q && !cfg_err) |-> (dst_vld[N_COL-1:M_LN-1] != '0));
  end else begin : g_comb
    assign dst_cols   = c_dst;
    assign dst_vld    = c_vld;
    assign back_lanes = c_back;
    assign cfg_err    = ~ok;
  end
endmodule

// File: tb/tb_spare_col_mux.sv
`timescale 1ns/1ps
module tb_spare_col_mux;
  localparam int N = 6;
  localparam int M = 3;
  localparam int W = 8;
  localparam int K = N - M;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [M*W-1:0] src_lanes = '0;
  logic [N-1:0]   col_sel   = '0;
  logic [N*W-1:0] back_cols = '0;
  logic [N*W-1:0] dst_cols;
  logic [N-1:0]   dst_vld;
  logic [M*W-1:0] back_lanes;
  logic           cfg_err;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  spare_col_mux #(.N_COL(N), .M_LN(M), .W(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .src_lanes(src_lanes), .col_sel(col_sel),
    .dst_cols(dst_cols), .dst_vld(dst_vld), .back_cols(back_cols),
    .back_lanes(back_lanes), .cfg_err(cfg_err)
  );

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_run++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s mask=%b actual=%0h expected=%0h", req, col_sel, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] e_dst;
    logic [N-1:0]   e_vld;
    logic [M*W-1:0] e_back;
    bit             e_err;
    int             cnt;
    int             prev;
    int             pos;
    repeat (3) @(negedge clk);
    // R8: reset clears everything
    check(dst_cols == '0 && dst_vld == '0 && back_lanes == '0 && !cfg_err,
          "R8 reset", longint'(dst_vld), 0);
    rst = 1'b0;
    for (int r = 0; r < 2; r++) begin
      for (int mk = 0; mk < (1 << N); mk++) begin
        col_sel = N'(mk);
        for (int i = 0; i < M; i++)
          src_lanes[i*W +: W] = W'(((i + 1) << 4) | ((mk + r) & 15));
        for (int j = 0; j < N; j++)
          back_cols[j*W +: W] = W'(8'h80 | (j << 3) | ((mk ^ r) & 7));
        e_dst = '0; e_vld = '0; e_back = '0; cnt = 0;
        for (int j = 0; j < N; j++) begin
          if (mk[j]) begin
            if (cnt < M) begin
              e_dst[j*W +: W]    = src_lanes[cnt*W +: W];
              e_back[cnt*W +: W] = back_cols[j*W +: W];
            end
            e_vld[j] = 1'b1;
            cnt++;
          end
        end
        e_err = (cnt != M);
        if (e_err) begin e_dst = '0; e_vld = '0; e_back = '0; end
        @(negedge clk);  // R8: one edge of latency
        check(cfg_err == e_err, "R2 error flag", cfg_err, e_err);
        if (e_err) begin
          check(dst_vld == '0 && dst_cols == '0 && back_lanes == '0,
                "R3 quiet on error", longint'(dst_cols), 0);
        end else begin
          check(dst_vld == e_vld, "R4 valid flags", dst_vld, e_vld);
          check(dst_cols == e_dst, "R1 R4 destination data", longint'(dst_cols), longint'(e_dst));
          check(back_lanes == e_back, "R7 reverse data", back_lanes, e_back);
          prev = -1;
          for (int i = 0; i < M; i++) begin
            pos = -1;
            for (int j = 0; j < N; j++)
              if (dst_vld[j] && dst_cols[j*W +: W] == src_lanes[i*W +: W]) pos = j;
            check(pos >= i && pos <= i + K, "R5 lane window", pos, i);
            check(pos > prev, "R6 no crossing", pos, prev + 1);
            prev = pos;
          end
        end
      end
    end
    rst = 1'b1;
    @(negedge clk);
    check(dst_cols == '0 && dst_vld == '0 && back_lanes == '0 && !cfg_err,
          "R8 reset after traffic", longint'(dst_vld), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule